// File: doc/BRIEF.md
# Interrupt Dispatch and Vector Locator

This block sits at the instruction boundary of a processor core. It holds four kinds of pending event: a system-management request, a debug trap, a non-maskable interrupt and a maskable interrupt. When the core signals a boundary, the block picks exactly one event by a fixed ranking and acknowledges it. For the maskable interrupt, that choice is only made while the interrupt-enable flag is set. The block then works out where the event's entry sits in the interrupt table and checks that entry against the table limit. If the entry fits, the block reads it over a simple memory read port.

In real mode an entry is a 4-byte far pointer, fetched with one 32-bit read. In protected mode an entry is an 8-byte descriptor, fetched as two 32-bit reads. The block decodes the gate type from the second word. From that type it reports whether the enable flag must be cleared and whether the entry is a task gate. The table base and limit are loaded through a write strobe. A system-management request is only acknowledged and finished; it never touches the table. Task switching and handler execution belong to the surrounding core.

Top module: `irq_dispatch_top`

## Requirements
- R1: A pending system-management request (ack bit 0) wins over every other pending event at a boundary.
- R2: A pending debug trap (ack bit 1) wins over NMI and INTR whenever no system-management request is pending.
- R3: NMI (ack bit 2) wins over INTR (ack bit 3). INTR is eligible only if `if_flag` is 1 at the boundary cycle; otherwise it stays pending and is not acknowledged.
- R4: A boundary accepted while idle gives one `ack` pulse, one cycle long, with a single bit set, in the cycle after the boundary. That source's pending bit is cleared. A request for the same source arriving in the accept cycle stays pending. Boundaries arriving while a dispatch is under way are ignored.
- R5: Vectors are 1 for the debug trap, 2 for NMI and `intr_vec` for INTR. In real mode the block issues one read at base + vector×4 and presents the word on `entry_lo`. In that case `entry_hi`, `gate_kind`, `clear_if` and `task_gate` are 0.
- R6: In protected mode the block issues two reads: base + vector×8 first, then that address + 4. The words appear on `entry_lo` and `entry_hi`.
- R7: If the entry's last byte offset (vector×size + size − 1) exceeds the limit, `limit_fault` pulses together with `done`, and no read is issued.
- R8: After reset the table base is 0 and the limit is 0x3FF, and all pulse outputs are 0. A `tbl_wr` cycle loads a new base and limit.
- R9: The gate type is `entry_hi[11:8]`. Types 0x6 and 0xE are interrupt gates (`gate_kind`=1, `clear_if`=1). Types 0x7 and 0xF are trap gates (`gate_kind`=2, `clear_if`=0). Type 0x5 is a task gate (`gate_kind`=3, `task_gate`=1). Any other type gives `gate_kind`=0 with both flags 0.
- R10: A system-management dispatch issues no read and pulses `done` in the cycle after its `ack`, with the entry outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smm_req | input | 1 | Sets the system-management pending bit |
| dbg_req | input | 1 | Sets the debug-trap pending bit |
| nmi_req | input | 1 | Sets the NMI pending bit |
| intr_req | input | 1 | Sets the maskable-interrupt pending bit |
| intr_vec | input | VEC_W | Vector number used for INTR |
| if_flag | input | 1 | Interrupt-enable flag; gates INTR |
| prot_mode | input | 1 | 1 = protected mode (8-byte entries), 0 = real mode |
| boundary | input | 1 | Instruction boundary strobe |
| tbl_wr | input | 1 | Loads the table base and limit |
| tbl_base_in | input | ADDR_W | New table base |
| tbl_limit_in | input | LIMIT_W | New table limit |
| ack | output | 4 | One-hot acknowledge: bit0 SMM, bit1 debug, bit2 NMI, bit3 INTR |
| mem_rd_en | output | 1 | Read request, one cycle per word |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | Dispatch finished (one-cycle pulse) |
| limit_fault | output | 1 | Entry beyond limit (pulses with done) |
| entry_lo | output | 32 | First entry word |
| entry_hi | output | 32 | Second entry word (protected mode) |
| gate_kind | output | 2 | 0 none, 1 interrupt gate, 2 trap gate, 3 task gate |
| clear_if | output | 1 | Enable flag must be cleared |
| task_gate | output | 1 | Entry is a task gate |

## Verification
Two things can happen in the same clock edge: the acknowledge that clears a pending bit, and a fresh request that sets that same bit again. The bench provokes this by raising `nmi_req` in the very cycle an NMI boundary is accepted. It then expects one acknowledge now and a second NMI dispatch at the next boundary. The entry fetch is swept over every vector in both modes. The expected addresses, faults and gate decodes are computed arithmetically from the base, limit and a memory model. The model places the vector's low bits in the type field.

// File: rtl/irq_disp_pkg.sv
// Package: shared types and constants for the interrupt dispatcher.
// Assumes a four-source ranking with index 0 the highest priority.
package irq_disp_pkg;

    localparam int NUM_SRC  = 4;
    localparam int SRC_SMM  = 0;
    localparam int SRC_DBG  = 1;
    localparam int SRC_NMI  = 2;
    localparam int SRC_INTR = 3;

    localparam logic [7:0] VEC_DBG = 8'd1;
    localparam logic [7:0] VEC_NMI = 8'd2;

    typedef enum logic [1:0] {
        GK_NONE = 2'd0,
        GK_INTR = 2'd1,
        GK_TRAP = 2'd2,
        GK_TASK = 2'd3
    } gate_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOC,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI
    } disp_state_e;

endpackage

// File: rtl/irq_prio_pick.sv
// Module: holds the pending event bits and picks one winner at a boundary.
// Index 0 is ranked highest. The bit at MASK_IDX is eligible only while
// the enable flag is high. Assumes 'idle' is high only when the
// dispatcher can accept a new event.
module irq_prio_pick #(
    parameter int NSRC     = 4,
    parameter int MASK_IDX = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            if_flag,
    input  logic            boundary,
    input  logic            idle,
    output logic            take,
    output logic [NSRC-1:0] win,
    output logic [NSRC-1:0] ack
);

    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] elig;
    logic [NSRC-1:0] clr;

    // Masks the maskable source with the enable flag.
    always_comb begin
        elig           = pend_q;
        elig[MASK_IDX] = pend_q[MASK_IDX] & if_flag;
    end

    // Fixed ranking: the lowest eligible index wins.
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && !found) begin
                win[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Accepts only at a boundary, while idle, with something eligible.
    always_comb begin
        take = boundary & idle & (|elig);
        clr  = take ? win : '0;
    end

    // Pending bits: set by requests, cleared by acknowledge; a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ack    <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | req;
            ack    <= clr;
        end
    end

    AST_SMM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend_q[0]) |=> ack[0]) else $error("smm lost");          // R1
    AST_DBG_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pend_q[1] && !pend_q[0]) |=> ack[1]) else $error("dbg lost"); // R2
    AST_INTR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack[MASK_IDX] |-> $past(if_flag)) else $error("masked intr acked");  // R3
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack)) else $error("ack not one-hot");                        // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> !(|ack)) else $error("ack longer than one cycle");         // R4

endmodule

// File: rtl/irq_entry_locate.sv
// Module: works out the table entry address and the limit check.
// Purely combinational. Entry size is 4 bytes in real mode and 8 in
// protected mode. Assumes vector*8+7 fits in VEC_W+4 bits.
module irq_entry_locate #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16,
    parameter int VEC_W   = 8
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [LIMIT_W-1:0] limit,
    input  logic [VEC_W-1:0]   vec,
    input  logic               prot,
    output logic [ADDR_W-1:0]  addr,
    output logic               fault
);

    localparam int OFF_W = VEC_W + 4;
    localparam int CMP_W = (OFF_W > LIMIT_W) ? OFF_W : LIMIT_W;

    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] last;

    // Scales the vector by the entry size and finds the last byte.
    always_comb begin
        off   = prot ? (OFF_W'(vec) << 3) : (OFF_W'(vec) << 2);
        last  = off + (prot ? OFF_W'(7) : OFF_W'(3));
        fault = CMP_W'(last) > CMP_W'(limit);
        addr  = base + ADDR_W'(off);
    end

endmodule

// File: rtl/irq_gate_decode.sv
// Module: decodes the gate type of a protected-mode descriptor high word.
// Assumes the 4-bit type field starts at TYPE_LSB.
module irq_gate_decode #(
    parameter int TYPE_LSB = 8
) (
    input  logic [31:0]                  hi_word,
    output irq_disp_pkg::gate_kind_e     kind,
    output logic                         clr_if,
    output logic                         is_task
);
    import irq_disp_pkg::*;

    logic [3:0] typ;

    // Maps the type nibble onto the gate kind and its side effects.
    always_comb begin
        typ = hi_word[TYPE_LSB +: 4];
        unique case (typ)
            4'h5:        kind = GK_TASK;
            4'h6, 4'hE:  kind = GK_INTR;
            4'h7, 4'hF:  kind = GK_TRAP;
            default:     kind = GK_NONE;
        endcase
        clr_if  = (kind == GK_INTR);
        is_task = (kind == GK_TASK);
    end

endmodule

// File: rtl/irq_dispatch_top.sv
// Module: interrupt dispatcher top. It ranks the pending events, locates
// the winner's table entry, checks the limit, fetches the entry and
// decodes the gate.
// Assumes the memory answers each read with one valid pulse at least one
// cycle after the request, and that the table is not reloaded while a
// dispatch is under way.
module irq_dispatch_top #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 16,
    parameter int VEC_W   = 8,
    parameter logic [LIMIT_W-1:0] RST_LIMIT = LIMIT_W'(16'h03FF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smm_req,
    input  logic               dbg_req,
    input  logic               nmi_req,
    input  logic               intr_req,
    input  logic [VEC_W-1:0]   intr_vec,
    input  logic               if_flag,
    input  logic               prot_mode,
    input  logic               boundary,
    input  logic               tbl_wr,
    input  logic [ADDR_W-1:0]  tbl_base_in,
    input  logic [LIMIT_W-1:0] tbl_limit_in,
    output logic [3:0]         ack,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_rd_valid,
    input  logic [31:0]        mem_rd_data,
    output logic               done,
    output logic               limit_fault,
    output logic [31:0]        entry_lo,
    output logic [31:0]        entry_hi,
    output logic [1:0]         gate_kind,
    output logic               clear_if,
    output logic               task_gate
);
    import irq_disp_pkg::*;

    localparam int HI_STEP = 4;

    disp_state_e          state_q;
    logic [ADDR_W-1:0]    base_q;
    logic [LIMIT_W-1:0]   limit_q;
    logic [VEC_W-1:0]     vec_q;
    logic [1:0]           src_q;
    logic                 prot_q;
    logic [ADDR_W-1:0]    addr_q;
    logic                 take;
    logic [NUM_SRC-1:0]   win;
    logic [1:0]           win_idx;
    logic [VEC_W-1:0]     win_vec;
    logic [ADDR_W-1:0]    loc_addr;
    logic                 loc_fault;
    gate_kind_e           dec_kind;
    logic                 dec_clr;
    logic                 dec_task;
    gate_kind_e           kind_q;

    irq_prio_pick #(.NSRC(NUM_SRC), .MASK_IDX(SRC_INTR)) prio_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      ({intr_req, nmi_req, dbg_req, smm_req}),
        .if_flag  (if_flag),
        .boundary (boundary),
        .idle     (state_q == ST_IDLE),
        .take     (take),
        .win      (win),
        .ack      (ack)
    );

    irq_entry_locate #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W)) loc_i (
        .base  (base_q),
        .limit (limit_q),
        .vec   (vec_q),
        .prot  (prot_q),
        .addr  (loc_addr),
        .fault (loc_fault)
    );

    irq_gate_decode #(.TYPE_LSB(8)) gate_i (
        .hi_word (mem_rd_data),
        .kind    (dec_kind),
        .clr_if  (dec_clr),
        .is_task (dec_task)
    );

    // Turns the one-hot winner into an index and its vector number.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (win[i]) win_idx = 2'(i);
        end
        case (win_idx)
            2'(SRC_DBG):  win_vec = VEC_W'(VEC_DBG);
            2'(SRC_NMI):  win_vec = VEC_W'(VEC_NMI);
            2'(SRC_INTR): win_vec = intr_vec;
            default:      win_vec = '0;
        endcase
    end

    // The read port is driven straight from the request states.
    always_comb begin
        mem_rd_en = (state_q == ST_REQ_LO) || (state_q == ST_REQ_HI);
        mem_addr  = addr_q;
        gate_kind = kind_q;
    end

    // Table register: reset defaults, software load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= RST_LIMIT;
        end else if (tbl_wr) begin
            base_q  <= tbl_base_in;
            limit_q <= tbl_limit_in;
        end
    end

    // Dispatch sequence: accept, locate, fetch, decode, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            vec_q       <= '0;
            src_q       <= '0;
            prot_q      <= 1'b0;
            addr_q      <= '0;
            done        <= 1'b0;
            limit_fault <= 1'b0;
            entry_lo    <= '0;
            entry_hi    <= '0;
            kind_q      <= GK_NONE;
            clear_if    <= 1'b0;
            task_gate   <= 1'b0;
        end else begin
            done        <= 1'b0;
            limit_fault <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        vec_q   <= win_vec;
                        src_q   <= win_idx;
                        prot_q  <= prot_mode;
                        state_q <= ST_LOC;
                    end
                end
                ST_LOC: begin
                    entry_lo  <= '0;
                    entry_hi  <= '0;
                    kind_q    <= GK_NONE;
                    clear_if  <= 1'b0;
                    task_gate <= 1'b0;
                    if (src_q == 2'(SRC_SMM)) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (loc_fault) begin
                        done        <= 1'b1;
                        limit_fault <= 1'b1;
                        state_q     <= ST_IDLE;
                    end else begin
                        addr_q  <= loc_addr;
                        state_q <= ST_REQ_LO;
                    end
                end
                ST_REQ_LO: state_q <= ST_WAIT_LO;
                ST_WAIT_LO: begin
                    if (mem_rd_valid) begin
                        entry_lo <= mem_rd_data;
                        if (prot_q) begin
                            addr_q  <= addr_q + ADDR_W'(HI_STEP);
                            state_q <= ST_REQ_HI;
                        end else begin
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_REQ_HI: state_q <= ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (mem_rd_valid) begin
                        entry_hi  <= mem_rd_data;
                        kind_q    <= dec_kind;
                        clear_if  <= dec_clr;
                        task_gate <= dec_task;
                        done      <= 1'b1;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_READ_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> ((mem_addr - base_q) + ADDR_W'(3)) <= ADDR_W'(limit_q))
        else $error("read past limit");                                        // R7
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault |-> done) else $error("fault without done");              // R7
    AST_SMM_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOC && src_q == 2'(SRC_SMM)) |=> (done && !mem_rd_en))
        else $error("smm fetched");                                            // R10
    AST_CLEAR_ONLY_INTR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        clear_if |-> (gate_kind == GK_INTR)) else $error("bad clear_if");      // R9
    AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> !take) else $error("second accept in flight");              // R4

endmodule

// File: tb/irq_dispatch_top_tb.sv
// Bench: sweeps vectors in both modes and checks ranking, masking, limits
// and gate decode against arithmetic expectations.
module irq_dispatch_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smm_req = 0, dbg_req = 0, nmi_req = 0, intr_req = 0;
    logic [7:0]  intr_vec = 8'h00;
    logic        if_flag = 1'b1, prot_mode = 1'b0, boundary = 1'b0;
    logic        tbl_wr = 1'b0;
    logic [31:0] tbl_base_in = '0;
    logic [15:0] tbl_limit_in = '0;
    logic [3:0]  ack;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        done, limit_fault, clear_if, task_gate;
    logic [31:0] entry_lo, entry_hi;
    logic [1:0]  gate_kind;

    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [2];
    logic [31:0] cur_base = 32'h0;
    logic [15:0] cur_limit = 16'h03FF;

    irq_dispatch_top dut_i (
        .clk(clk), .rst_n(rst_n), .smm_req(smm_req), .dbg_req(dbg_req),
        .nmi_req(nmi_req), .intr_req(intr_req), .intr_vec(intr_vec),
        .if_flag(if_flag), .prot_mode(prot_mode), .boundary(boundary),
        .tbl_wr(tbl_wr), .tbl_base_in(tbl_base_in), .tbl_limit_in(tbl_limit_in),
        .ack(ack), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .done(done),
        .limit_fault(limit_fault), .entry_lo(entry_lo), .entry_hi(entry_hi),
        .gate_kind(gate_kind), .clear_if(clear_if), .task_gate(task_gate)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory model word: the type nibble [11:8] comes from address bits [6:3].
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, 4'h8, a[6:3], a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Memory responder: one valid pulse, one cycle after each request.
    initial begin
        bit pend_rsp = 0;
        logic [31:0] rsp_addr = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend_rsp) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_word(rsp_addr);
                pend_rsp     = 0;
            end
            if (mem_rd_en) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_addr;
                rd_cnt++;
                rsp_addr = mem_addr;
                pend_rsp = 1;
            end
        end
    end

    task automatic load_table(input logic [31:0] b, input logic [15:0] l);
        @(negedge clk);
        tbl_wr = 1'b1; tbl_base_in = b; tbl_limit_in = l;
        @(negedge clk);
        tbl_wr = 1'b0;
        cur_base = b; cur_limit = l;
    endtask

    task automatic pulse_req(input logic [3:0] m);
        @(negedge clk);
        {intr_req, nmi_req, dbg_req, smm_req} = m;
        @(negedge clk);
        {intr_req, nmi_req, dbg_req, smm_req} = 4'b0;
    endtask

    // One dispatch with the full expected outcome computed here.
    task automatic dispatch(input int src, input logic [3:0] extra, input string req);
        int          vec, size, off;
        bit          flt, seen;
        logic [31:0] a0, w0, w1;
        logic [3:0]  nib;
        logic [1:0]  ek;
        vec  = (src == 1) ? 1 : (src == 2) ? 2 : int'(intr_vec);
        size = prot_mode ? 8 : 4;
        off  = vec * size;
        flt  = (off + size - 1) > int'(cur_limit);
        a0   = cur_base + 32'(off);
        rd_cnt = 0;
        @(negedge clk);
        boundary = 1'b1;
        {intr_req, nmi_req, dbg_req, smm_req} = extra;
        @(negedge clk);
        boundary = 1'b0;
        {intr_req, nmi_req, dbg_req, smm_req} = 4'b0;
        chk(ack == (4'b1 << src), req, "ack", 32'(ack), 32'(4'b1 << src));
        seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, req, "done seen", 32'(seen), 32'd1);
        if (src == 0) begin
            chk(rd_cnt == 0 && entry_lo == 0 && !limit_fault, "R10", "smm no read",
                32'(rd_cnt), 32'd0);
        end else if (flt) begin
            chk(limit_fault && rd_cnt == 0, "R7", "limit fault",
                {limit_fault, 31'(rd_cnt)}, {1'b1, 31'd0});
        end else begin
            w0 = mem_word(a0);
            chk(!limit_fault && rd_cnt == (prot_mode ? 2 : 1), prot_mode ? "R6" : "R5",
                "read count", 32'(rd_cnt), prot_mode ? 32'd2 : 32'd1);
            chk(rd_addr[0] == a0, prot_mode ? "R6" : "R5", "first addr", rd_addr[0], a0);
            chk(entry_lo == w0, prot_mode ? "R6" : "R5", "entry_lo", entry_lo, w0);
            if (prot_mode) begin
                w1  = mem_word(a0 + 32'd4);
                nib = w1[11:8];
                ek  = (nib == 4'h5) ? 2'd3 : (nib == 4'h6 || nib == 4'hE) ? 2'd1 :
                      (nib == 4'h7 || nib == 4'hF) ? 2'd2 : 2'd0;
                chk(rd_addr[1] == a0 + 32'd4, "R6", "second addr", rd_addr[1], a0 + 32'd4);
                chk(entry_hi == w1, "R6", "entry_hi", entry_hi, w1);
                chk(gate_kind == ek && clear_if == (ek == 2'd1) && task_gate == (ek == 2'd3),
                    "R9", "gate decode", {gate_kind, clear_if, task_gate},
                    {ek, ek == 2'd1, ek == 2'd3});
            end else begin
                chk(entry_hi == 0 && gate_kind == 0 && !clear_if && !task_gate, "R5",
                    "real mode gate outputs", {gate_kind, clear_if, task_gate}, 32'd0);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        wrap_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(ack == 0 && !done && !limit_fault && !mem_rd_en, "R8", "reset outputs",
            {ack, done, limit_fault, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset table defaults, base 0 limit 0x3FF
        prot_mode = 0; intr_vec = 8'hFF; pulse_req(4'b1000); dispatch(3, 4'b0, "R8");
        prot_mode = 1; intr_vec = 8'h7F; pulse_req(4'b1000); dispatch(3, 4'b0, "R8");
        intr_vec = 8'h80; pulse_req(4'b1000); dispatch(3, 4'b0, "R8");
        // R5, R6, R7, R9: full vector sweeps in both modes
        load_table(32'h0012_3400, 16'h03FF);
        for (int m = 0; m < 2; m++) begin
            prot_mode = m[0];
            for (int v = 0; v < 256; v++) begin
                intr_vec = 8'(v);
                pulse_req(4'b1000);
                dispatch(3, 4'b0, "R6");
            end
        end
        // R7: limit boundaries with a small limit
        load_table(32'h0000_8000, 16'h007F);
        prot_mode = 0; intr_vec = 8'd31; pulse_req(4'b1000); dispatch(3, 4'b0, "R7");
        intr_vec = 8'd32; pulse_req(4'b1000); dispatch(3, 4'b0, "R7");
        prot_mode = 1; intr_vec = 8'd15; pulse_req(4'b1000); dispatch(3, 4'b0, "R7");
        intr_vec = 8'd16; pulse_req(4'b1000); dispatch(3, 4'b0, "R7");
        // R1, R2, R3: ranking with all four pending
        load_table(32'h0040_0000, 16'h03FF);
        prot_mode = 0; intr_vec = 8'h40;
        pulse_req(4'b1111);
        dispatch(0, 4'b0, "R1");
        dispatch(1, 4'b0, "R2");
        dispatch(2, 4'b0, "R3");
        dispatch(3, 4'b0, "R3");
        // R3: INTR held off while the enable flag is low
        if_flag = 0;
        pulse_req(4'b1000);
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
        chk(ack == 0, "R3", "masked intr not acked", 32'(ack), 32'd0);
        repeat (3) @(negedge clk);
        chk(ack == 0 && !done && !mem_rd_en, "R3", "masked intr idle",
            {ack, done, mem_rd_en}, 32'd0);
        if_flag = 1;
        dispatch(3, 4'b0, "R3");
        // R4: a request in the accept cycle survives the clear
        pulse_req(4'b0100);
        dispatch(2, 4'b0100, "R4");
        dispatch(2, 4'b0, "R4");
        // R4: a boundary during a dispatch is ignored
        prot_mode = 1;
        pulse_req(4'b0100);
        rd_cnt = 0;
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b1;
        @(negedge clk); boundary = 1'b0;
        chk(ack == 0, "R4", "no second ack in flight", 32'(ack), 32'd0);
        repeat (10) @(negedge clk);
        chk(rd_cnt == 2, "R4", "single dispatch reads", 32'(rd_cnt), 32'd2);
        // R10: system-management request alone
        pulse_req(4'b0001);
        dispatch(0, 4'b0, "R10");
        repeat (3) @(negedge clk);
        wrap_up();
    end

endmodule